// File: doc/BRIEF.md
# Region Memory Access Filter

This block is an address-space firewall that sits between bus initiators and one memory port. Software programs up to four regions, each a page range between an inclusive base page and an inclusive limit page (4 KiB pages). Every region carries an enable, a secure-only flag, a privileged-only flag, a switch that turns on per-initiator filtering, and three per-initiator bitmaps: read allowed, write allowed and privilege required. Each transaction carries an initiator identifier (the CID), a secure bit and a privilege bit. The block compares the transaction with all regions in the same cycle, picks the lowest-numbered enabled region that contains the address, and checks the rules of that region.

An allowed transaction passes to the memory port in the same cycle. A blocked write never reaches the memory. A blocked read is not forwarded either, and the read data returned upstream one cycle later is forced to zero. Each blocked access raises a one-cycle violation pulse, one cycle after the request, that reports the address, the CID and whether the access was a write. One reserved debug CID passes every check. The memory is assumed to return read data one cycle after it accepts a read.

Top module: `rmf_filter`

## Requirements
- R1: After reset every region is disabled, so any access with a CID other than the debug CID is blocked.
- R2: A region matches an address whose page number (address bits 31:12) lies between its base page and its limit page, both ends included; an address one page beyond the limit or one page below the base does not match.
- R3: When several enabled regions contain the address, only the rules of the lowest-numbered one apply.
- R4: If the matched region has its secure-only attribute (attribute bit 1) set, a non-secure access is blocked; if clear, secure and non-secure accesses both pass this rule.
- R5: If per-CID filtering (attribute bit 3) is off and the privileged-only attribute (attribute bit 2) is set, an unprivileged access is blocked.
- R6: If per-CID filtering is on, a read passes only when the CID's bit is set in the read bitmap and a write only when it is set in the write bitmap; the region's privileged-only attribute is then ignored.
- R7: If per-CID filtering is on and the CID's bit is set in the privilege bitmap, an unprivileged access with that CID is blocked.
- R8: A blocked access drives no request to the memory port; an allowed access is forwarded in the same cycle with its address and write flag.
- R9: One cycle after a read, the upstream read data equals the memory data if the read was allowed and zero if it was blocked.
- R10: An access with the debug CID (default 7) is allowed regardless of region configuration.
- R11: One cycle after a blocked access, a single-cycle violation pulse reports its address, CID and write flag; allowed accesses raise no pulse.
- R12: An address inside no enabled region is blocked, including an address covered only by a region whose enable (attribute bit 0) is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Region selected for the configuration write |
| cfg_sel | input | 3 | Field: 0 base page, 1 limit page, 2 attributes, 3 read bitmap, 4 write bitmap, 5 privilege bitmap |
| cfg_wdata | input | 32 | Configuration value, right-aligned |
| req_valid | input | 1 | Transaction present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_cid | input | 3 | Initiator identifier |
| req_secure | input | 1 | Access is secure |
| req_priv | input | 1 | Access is privileged |
| mem_valid | output | 1 | Forwarded transaction to memory |
| mem_write | output | 1 | Forwarded write flag |
| mem_addr | output | 32 | Forwarded address |
| mem_wdata | output | 32 | Forwarded write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the read |
| rsp_valid | output | 1 | Read response cycle |
| rsp_rdata | output | 32 | Read data to initiator, zero when blocked |
| viol_valid | output | 1 | Violation pulse |
| viol_write | output | 1 | Blocked access was a write |
| viol_addr | output | 32 | Blocked address |
| viol_cid | output | 3 | Blocked CID |

## Verification
The assertions watch, on every cycle, that a violation pulse only follows a request that was not forwarded, that a blocked read returns zero, that the debug CID is always forwarded, that an unmatched address or a non-secure access to a secure region is never forwarded, and that the violation address follows the request. Region bounds at their exact edges, the choice among overlapping regions, the per-CID bitmaps with privilege, and the disabled-region case depend on programmed configuration and are shown only by the bench scenarios, which compare forwarding, read data and violation fields against expectations built from the rules.

// File: rtl/rmf_pkg.sv
// Package: shared encodings for the region memory access filter.
// Assumes: configuration field selector is 3 bits wide; attribute bits
// are packed at fixed positions inside the attribute word.
package rmf_pkg;
    typedef enum logic [2:0] {
        CFG_BASE     = 3'd0,
        CFG_LIMIT    = 3'd1,
        CFG_ATTR     = 3'd2,
        CFG_RDMAP    = 3'd3,
        CFG_WRMAP    = 3'd4,
        CFG_PVMAP    = 3'd5
    } cfg_field_e;

    localparam int ATTR_ENABLE = 0;
    localparam int ATTR_SECURE = 1;
    localparam int ATTR_PRIV   = 2;
    localparam int ATTR_CIDF   = 3;
endpackage

// File: rtl/rmf_region_regs.sv
// Module: configuration storage for all regions.
// Does: holds base/limit page, attributes and per-CID bitmaps per region,
// written one field at a time. Assumes PAGE_W and NUM_CIDS fit in CFG_W.
module rmf_region_regs
    import rmf_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int PAGE_W      = 20,
    parameter int NUM_CIDS    = 8,
    parameter int CFG_W       = 32,
    parameter int IDX_W       = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_we,
    input  logic [IDX_W-1:0]                       cfg_idx,
    input  logic [2:0]                             cfg_sel,
    input  logic [CFG_W-1:0]                       cfg_wdata,
    output logic [NUM_REGIONS-1:0][PAGE_W-1:0]     base_pg,
    output logic [NUM_REGIONS-1:0][PAGE_W-1:0]     limit_pg,
    output logic [NUM_REGIONS-1:0]                 en,
    output logic [NUM_REGIONS-1:0]                 sec,
    output logic [NUM_REGIONS-1:0]                 gpriv,
    output logic [NUM_REGIONS-1:0]                 cidf,
    output logic [NUM_REGIONS-1:0][NUM_CIDS-1:0]   rd_map,
    output logic [NUM_REGIONS-1:0][NUM_CIDS-1:0]   wr_map,
    output logic [NUM_REGIONS-1:0][NUM_CIDS-1:0]   pv_map
);
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        logic hit;
        assign hit = cfg_we && (cfg_idx == IDX_W'(g));

        // Update the addressed field of this region; clear all on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_pg[g]  <= '0;
                limit_pg[g] <= '0;
                en[g]       <= 1'b0;
                sec[g]      <= 1'b0;
                gpriv[g]    <= 1'b0;
                cidf[g]     <= 1'b0;
                rd_map[g]   <= '0;
                wr_map[g]   <= '0;
                pv_map[g]   <= '0;
            end else if (hit) begin
                case (cfg_field_e'(cfg_sel))
                    CFG_BASE:  base_pg[g]  <= cfg_wdata[PAGE_W-1:0];
                    CFG_LIMIT: limit_pg[g] <= cfg_wdata[PAGE_W-1:0];
                    CFG_ATTR: begin
                        en[g]    <= cfg_wdata[ATTR_ENABLE];
                        sec[g]   <= cfg_wdata[ATTR_SECURE];
                        gpriv[g] <= cfg_wdata[ATTR_PRIV];
                        cidf[g]  <= cfg_wdata[ATTR_CIDF];
                    end
                    CFG_RDMAP: rd_map[g] <= cfg_wdata[NUM_CIDS-1:0];
                    CFG_WRMAP: wr_map[g] <= cfg_wdata[NUM_CIDS-1:0];
                    CFG_PVMAP: pv_map[g] <= cfg_wdata[NUM_CIDS-1:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rmf_match.sv
// Module: parallel region match with fixed priority.
// Does: compares the request page with every enabled region's inclusive
// bounds at once and returns the lowest-numbered hit. Purely combinational.
module rmf_match #(
    parameter int NUM_REGIONS = 4,
    parameter int PAGE_W      = 20,
    parameter int IDX_W       = 2
) (
    input  logic [PAGE_W-1:0]                   page,
    input  logic [NUM_REGIONS-1:0][PAGE_W-1:0]  base_pg,
    input  logic [NUM_REGIONS-1:0][PAGE_W-1:0]  limit_pg,
    input  logic [NUM_REGIONS-1:0]              en,
    output logic                                hit_any,
    output logic [IDX_W-1:0]                    hit_idx
);
    logic [NUM_REGIONS-1:0] hit_vec;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        assign hit_vec[g] = en[g] && (page >= base_pg[g]) && (page <= limit_pg[g]);
    end

    // Priority pick: scan downward so the lowest index is taken last.
    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rmf_check.sv
// Module: permission check against the selected region.
// Does: applies secure, global-privilege or per-CID rules and the debug
// bypass. Assumes hit_idx is meaningful only when hit_any is high.
module rmf_check #(
    parameter int NUM_REGIONS = 4,
    parameter int NUM_CIDS    = 8,
    parameter int CID_W       = 3,
    parameter int IDX_W       = 2,
    parameter int DEBUG_CID   = 7
) (
    input  logic                                  req_write,
    input  logic [CID_W-1:0]                      req_cid,
    input  logic                                  req_secure,
    input  logic                                  req_priv,
    input  logic                                  hit_any,
    input  logic [IDX_W-1:0]                      hit_idx,
    input  logic [NUM_REGIONS-1:0]                sec,
    input  logic [NUM_REGIONS-1:0]                gpriv,
    input  logic [NUM_REGIONS-1:0]                cidf,
    input  logic [NUM_REGIONS-1:0][NUM_CIDS-1:0]  rd_map,
    input  logic [NUM_REGIONS-1:0][NUM_CIDS-1:0]  wr_map,
    input  logic [NUM_REGIONS-1:0][NUM_CIDS-1:0]  pv_map,
    output logic                                  grant
);
    logic sec_ok, gpriv_ok, cid_ok, rule_ok, is_dbg;

    // Evaluate every rule for the selected region and combine them.
    always_comb begin
        is_dbg   = (req_cid == CID_W'(DEBUG_CID));
        sec_ok   = !sec[hit_idx] || req_secure;
        gpriv_ok = !gpriv[hit_idx] || req_priv;
        cid_ok   = (req_write ? wr_map[hit_idx][req_cid] : rd_map[hit_idx][req_cid])
                   && (!pv_map[hit_idx][req_cid] || req_priv);
        rule_ok  = hit_any && sec_ok && (cidf[hit_idx] ? cid_ok : gpriv_ok);
        grant    = is_dbg || rule_ok;
    end
endmodule

// File: rtl/rmf_filter.sv
// Module: top of the region memory access filter.
// Does: forwards allowed transactions combinationally, zeroes blocked read
// data and pulses a violation report one cycle after a blocked request.
// Assumes the memory returns read data one cycle after accepting a read.
module rmf_filter #(
    parameter int  ADDR_W      = 32,
    parameter int  DATA_W      = 32,
    parameter int  CID_W       = 3,
    parameter int  NUM_REGIONS = 4,
    parameter int  PAGE_SHIFT  = 12,
    parameter int  DEBUG_CID   = 7,
    parameter int  CFG_W       = 32,
    localparam int IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [2:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CID_W-1:0]  req_cid,
    input  logic              req_secure,
    input  logic              req_priv,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              viol_valid,
    output logic              viol_write,
    output logic [ADDR_W-1:0] viol_addr,
    output logic [CID_W-1:0]  viol_cid
);
    localparam int PAGE_W   = ADDR_W - PAGE_SHIFT;
    localparam int NUM_CIDS = 1 << CID_W;

    logic [NUM_REGIONS-1:0][PAGE_W-1:0]   base_pg, limit_pg;
    logic [NUM_REGIONS-1:0]               en, sec, gpriv, cidf;
    logic [NUM_REGIONS-1:0][NUM_CIDS-1:0] rd_map, wr_map, pv_map;
    logic                                 hit_any, grant;
    logic [IDX_W-1:0]                     hit_idx;
    logic                                 rd_ok_q;

    rmf_region_regs #(
        .NUM_REGIONS(NUM_REGIONS), .PAGE_W(PAGE_W), .NUM_CIDS(NUM_CIDS),
        .CFG_W(CFG_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .base_pg(base_pg), .limit_pg(limit_pg), .en(en), .sec(sec),
        .gpriv(gpriv), .cidf(cidf), .rd_map(rd_map), .wr_map(wr_map),
        .pv_map(pv_map)
    );

    rmf_match #(
        .NUM_REGIONS(NUM_REGIONS), .PAGE_W(PAGE_W), .IDX_W(IDX_W)
    ) u_match (
        .page(req_addr[ADDR_W-1:PAGE_SHIFT]), .base_pg(base_pg),
        .limit_pg(limit_pg), .en(en), .hit_any(hit_any), .hit_idx(hit_idx)
    );

    rmf_check #(
        .NUM_REGIONS(NUM_REGIONS), .NUM_CIDS(NUM_CIDS), .CID_W(CID_W),
        .IDX_W(IDX_W), .DEBUG_CID(DEBUG_CID)
    ) u_check (
        .req_write(req_write), .req_cid(req_cid), .req_secure(req_secure),
        .req_priv(req_priv), .hit_any(hit_any), .hit_idx(hit_idx),
        .sec(sec), .gpriv(gpriv), .cidf(cidf), .rd_map(rd_map),
        .wr_map(wr_map), .pv_map(pv_map), .grant(grant)
    );

    // Forward only granted transactions to the memory port.
    always_comb begin
        mem_valid = req_valid && grant;
        mem_write = req_write;
        mem_addr  = req_addr;
        mem_wdata = req_wdata;
    end

    // Track read responses and capture the violation report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rd_ok_q    <= 1'b0;
            viol_valid <= 1'b0;
            viol_write <= 1'b0;
            viol_addr  <= '0;
            viol_cid   <= '0;
        end else begin
            rsp_valid  <= req_valid && !req_write;
            rd_ok_q    <= req_valid && !req_write && grant;
            viol_valid <= req_valid && !grant;
            if (req_valid && !grant) begin
                viol_write <= req_write;
                viol_addr  <= req_addr;
                viol_cid   <= req_cid;
            end
        end
    end

    // Return memory data only for reads that were let through.
    assign rsp_rdata = rd_ok_q ? mem_rdata : '0;

    AST_VIOL_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> ($past(req_valid) && !$past(mem_valid)));                      // R8
    AST_READ_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(mem_valid)) |-> (rsp_rdata == '0));                      // R9
    AST_DEBUG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cid == CID_W'(DEBUG_CID)) |-> mem_valid);                   // R10
    AST_NOMATCH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit_any && req_cid != CID_W'(DEBUG_CID)) |-> !mem_valid);      // R12
    AST_SECURE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit_any && sec[hit_idx] && !req_secure
         && req_cid != CID_W'(DEBUG_CID)) |-> !mem_valid);                            // R4
    AST_VIOL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (viol_addr == $past(req_addr)));                               // R11
endmodule

// File: tb/sim_rmf_filter.sv
// Scoreboard bench: the driver forwards-checks each access and queues its
// expected response; the monitor pops one item per clock and compares.
module sim_rmf_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0, req_priv = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [2:0]  req_cid = '0;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, viol_valid, viol_write;
    logic [31:0] rsp_rdata, viol_addr;
    logic [2:0]  viol_cid;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic        grant;
        logic        write;
        logic [31:0] addr;
        logic [2:0]  cid;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    rmf_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_cid(req_cid), .req_secure(req_secure), .req_priv(req_priv),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .viol_valid(viol_valid), .viol_write(viol_write),
        .viol_addr(viol_addr), .viol_cid(viol_cid)
    );

    function automatic logic [31:0] mem_pattern(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    // Memory model: read data one cycle after an accepted read.
    always @(posedge clk)
        mem_rdata <= (mem_valid && !mem_write) ? mem_pattern(mem_addr) : 32'hDEAD_BEEF;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic w, input logic [31:0] a, input logic [2:0] c,
                          input logic s, input logic p, input logic exp, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_cid = c;
        req_secure = s; req_priv = p; req_wdata = ~a;
        #1;
        check(mem_valid == exp, tag, "mem_valid", 32'(mem_valid), 32'(exp));
        if (exp)
            check(mem_addr == a && mem_write == w, tag, "forwarded addr", mem_addr, a);
        e.grant = exp; e.write = w; e.addr = a; e.cid = c; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare the registered response for the queued request.
    initial begin
        forever begin
            @(posedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                #2;
                check(viol_valid == !e.grant, e.tag, "viol_valid", 32'(viol_valid), 32'(!e.grant));
                if (!e.grant) begin
                    check(viol_addr == e.addr, e.tag, "viol_addr (R11)", viol_addr, e.addr);
                    check(viol_cid == e.cid, e.tag, "viol_cid (R11)", 32'(viol_cid), 32'(e.cid));
                    check(viol_write == e.write, e.tag, "viol_write (R11)", 32'(viol_write), 32'(e.write));
                end
                if (!e.write) begin
                    logic [31:0] ed;
                    ed = e.grant ? mem_pattern(e.addr) : 32'h0;
                    check(rsp_valid == 1'b1, e.tag, "rsp_valid", 32'(rsp_valid), 32'h1);
                    check(rsp_rdata == ed, e.tag, "rsp_rdata (R9)", rsp_rdata, ed);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        check(viol_valid == 1'b0 && rsp_valid == 1'b0, "R1", "reset outputs", 32'(viol_valid), 32'h0);
        check(rsp_rdata == 32'h0, "R1", "reset rdata", rsp_rdata, 32'h0);
        access(1'b0, 32'h0000_1000, 3'd1, 1'b1, 1'b1, 1'b0, "R1");
        access(1'b1, 32'h0000_1000, 3'd1, 1'b1, 1'b1, 1'b0, "R1");
        idle();

        // Region 0: pages 0x10..0x1F, enabled, open
        cfg(0, 3'd0, 32'h10);
        cfg(0, 3'd1, 32'h1F);
        cfg(0, 3'd2, 32'h1);
        access(1'b0, 32'h0001_0000, 3'd1, 1'b0, 1'b0, 1'b1, "R2");
        access(1'b0, 32'h0001_FFFC, 3'd1, 1'b0, 1'b0, 1'b1, "R2");
        access(1'b0, 32'h0002_0000, 3'd1, 1'b0, 1'b0, 1'b0, "R2");
        access(1'b0, 32'h0000_FFFC, 3'd2, 1'b0, 1'b0, 1'b0, "R2");
        access(1'b1, 32'h0001_0004, 3'd1, 1'b0, 1'b0, 1'b1, "R8");
        access(1'b1, 32'h0003_0000, 3'd4, 1'b0, 1'b0, 1'b0, "R8");
        idle();

        // Region 1: pages 0x18..0x2F, secure only, overlaps region 0
        cfg(1, 3'd0, 32'h18);
        cfg(1, 3'd1, 32'h2F);
        cfg(1, 3'd2, 32'h3);
        access(1'b0, 32'h0001_8000, 3'd1, 1'b0, 1'b0, 1'b1, "R3");
        access(1'b0, 32'h0002_4000, 3'd1, 1'b0, 1'b0, 1'b0, "R4");
        access(1'b0, 32'h0002_4000, 3'd1, 1'b1, 1'b0, 1'b1, "R4");
        access(1'b1, 32'h0001_0000, 3'd3, 1'b1, 1'b0, 1'b1, "R4");
        idle();

        // Region 0 becomes privileged-only (no per-CID filtering)
        cfg(0, 3'd2, 32'h5);
        access(1'b0, 32'h0001_0000, 3'd1, 1'b0, 1'b0, 1'b0, "R5");
        access(1'b0, 32'h0001_0000, 3'd1, 1'b0, 1'b1, 1'b1, "R5");
        idle();

        // Region 2: page 0x40, per-CID filtering, global priv set but ignored
        cfg(2, 3'd0, 32'h40);
        cfg(2, 3'd1, 32'h40);
        cfg(2, 3'd2, 32'hD);
        cfg(2, 3'd3, 32'h06);
        cfg(2, 3'd4, 32'h04);
        cfg(2, 3'd5, 32'h04);
        access(1'b0, 32'h0004_0010, 3'd1, 1'b0, 1'b0, 1'b1, "R6");
        access(1'b1, 32'h0004_0010, 3'd1, 1'b0, 1'b1, 1'b0, "R6");
        access(1'b0, 32'h0004_0010, 3'd3, 1'b0, 1'b1, 1'b0, "R6");
        access(1'b1, 32'h0004_0020, 3'd2, 1'b0, 1'b0, 1'b0, "R7");
        access(1'b1, 32'h0004_0020, 3'd2, 1'b0, 1'b1, 1'b1, "R7");
        access(1'b0, 32'h0004_0020, 3'd2, 1'b0, 1'b1, 1'b1, "R7");
        access(1'b0, 32'h0004_1000, 3'd2, 1'b0, 1'b1, 1'b0, "R2");
        idle();

        // Debug CID bypass
        access(1'b0, 32'h0009_0000, 3'd7, 1'b0, 1'b0, 1'b1, "R10");
        access(1'b1, 32'h0002_4000, 3'd7, 1'b0, 1'b0, 1'b1, "R10");
        idle();

        // Region 3 configured but not enabled
        cfg(3, 3'd0, 32'h50);
        cfg(3, 3'd1, 32'h5F);
        cfg(3, 3'd3, 32'hFF);
        cfg(3, 3'd2, 32'h0);
        access(1'b0, 32'h0005_0000, 3'd1, 1'b1, 1'b1, 1'b0, "R12");
        access(1'b1, 32'h0005_8000, 3'd0, 1'b1, 1'b1, 1'b0, "R12");
        idle();

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R11", "scoreboard drained", 32'(sb.size()), 32'h0);
        check(viol_valid == 1'b0, "R11", "no pulse when idle", 32'(viol_valid), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule